// File: doc/BRIEF.md
# Speculative reorder buffer

This block keeps in-flight instructions in program order so that speculative work can run ahead of branch resolution without touching architectural state. The issue stage asks for an entry per instruction and receives a tag. Execution units later return a result against that tag. The result stays inside the buffer until the entry reaches the head, where a separate commit step hands it to the register file or to memory. Entries leave in order, one per cycle at most. A store or register write is visible outside the buffer only on its commit cycle.

Branches also pass through the buffer. A correctly predicted branch commits with no write and the entries behind it keep their turn. A mispredicted branch discards every younger entry in the cycle it commits. In the following cycle the block presents the corrected fetch address for one cycle. A small state machine handles this. In RUN the buffer accepts, writes back and commits. The RUN to REDIRECT transition is taken when a mispredicted branch commits. In REDIRECT the redirect output is driven and allocation is refused. REDIRECT always returns to RUN after one cycle. Any other RUN cycle stays in RUN.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, commit_valid is 0 and redirect_valid is 0.
- R2: Accepted allocations receive consecutive tags, counting upward modulo the depth (8 by default) from the tag after the newest live entry. The tag is the slot index shown on alloc_tag in the cycle of acceptance.
- R3: With 8 live entries alloc_ready is 0 and a request on alloc_valid adds no entry. After all 8 commit, nothing further commits and alloc_tag equals the tag that followed the eighth entry.
- R4: Only the oldest entry commits. It commits in the cycle after its result was written back, at most one entry commits per cycle, and a result returned for a younger entry never lets it commit ahead of an older one.
- R5: A committing entry of kind ALU (alloc_kind 0) or load (1) asserts reg_we with its destination on reg_dest and its result on reg_value, with store_we at 0.
- R6: A committing store (kind 2) asserts store_we with the address and data from its writeback (wb_addr and wb_value), with reg_we at 0.
- R7: A committing branch (kind 3) written back with wb_mispredict at 0 asserts neither reg_we nor store_we nor redirect_valid, and the entries after it commit in later cycles.
- R8: A committing branch with wb_mispredict at 1 asserts no write, and alloc_ready is 0 in that cycle. It discards every younger entry, ready or not. In the next cycle redirect_valid is 1 for exactly one cycle with redirect_pc equal to its wb_target, while commit_valid and alloc_ready are 0.
- R9: A writeback whose tag names a slot that holds no live entry is ignored. An entry later allocated to that slot commits only after a writeback of its own.
- R10: After a flush the first new allocation receives the tag that follows the mispredicted branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue stage requests an entry |
| alloc_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 branch |
| alloc_dest | input | REG_W | Destination register of the new entry |
| alloc_ready | output | 1 | Request is accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the new entry |
| wb_valid | input | 1 | Execution unit returns a result |
| wb_tag | input | TAG_W | Entry the result belongs to |
| wb_value | input | DATA_W | Result, or store data |
| wb_addr | input | ADDR_W | Store address |
| wb_mispredict | input | 1 | Branch outcome disagreed with the prediction |
| wb_target | input | ADDR_W | Correct fetch address of a branch |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring entry |
| commit_kind | output | 2 | Kind of the retiring entry |
| reg_we | output | 1 | Register file write enable |
| reg_dest | output | REG_W | Register written |
| reg_value | output | DATA_W | Value written |
| store_we | output | 1 | Memory write enable |
| store_addr | output | ADDR_W | Memory address written |
| store_data | output | DATA_W | Memory data written |
| redirect_valid | output | 1 | Fetch must restart |
| redirect_pc | output | ADDR_W | Address to restart at |

## Verification
The hardest case is a flush while younger entries are already finished. Slots then hold ready results that must not escape, and stale ready bits must not survive into the next allocation of those slots. The stimulus returns results for the entries behind a branch before the branch's own result, so they sit ready when the mispredicted branch reaches the head. An allocation request is raised during the flush cycle. The stimulus then reallocates one discarded slot after a stray writeback to it and checks that it waits for its own result. A full buffer is also filled across the pointer wrap before it is drained.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_LOAD   = 2'd1,
        K_STORE  = 2'd2,
        K_BRANCH = 2'd3
    } rob_kind_e;

    typedef enum logic {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count
);

    logic [TAG_W-1:0] head_inc;

    assign head_inc = head + TAG_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= head_inc;
            tail  <= head_inc;
            count <= '0;
        end else begin
            if (pop) begin
                head <= head_inc;
            end
            if (push) begin
                tail <= tail + TAG_W'(1);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_we,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  rob_kind_e         alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              wb_we,
    input  logic [TAG_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_mis,
    input  logic [ADDR_W-1:0] wb_target,
    input  logic              pop,
    input  logic [TAG_W-1:0]  head_idx,
    output logic              hd_valid,
    output logic              hd_ready,
    output rob_kind_e         hd_kind,
    output logic [REG_W-1:0]  hd_dest,
    output logic [DATA_W-1:0] hd_value,
    output logic [ADDR_W-1:0] hd_addr,
    output logic              hd_mis,
    output logic [ADDR_W-1:0] hd_target
);

    logic              v_q    [DEPTH];
    logic              r_q    [DEPTH];
    rob_kind_e         kind_q [DEPTH];
    logic [REG_W-1:0]  dest_q [DEPTH];
    logic [DATA_W-1:0] val_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic              mis_q  [DEPTH];
    logic [ADDR_W-1:0] tgt_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_alloc;
        logic hit_wb;
        logic hit_pop;

        assign hit_alloc = alloc_we && (alloc_idx == TAG_W'(g));
        assign hit_wb    = wb_we && (wb_idx == TAG_W'(g)) && v_q[g];
        assign hit_pop   = pop && (head_idx == TAG_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[g]    <= 1'b0;
                r_q[g]    <= 1'b0;
                kind_q[g] <= K_ALU;
                dest_q[g] <= '0;
                val_q[g]  <= '0;
                addr_q[g] <= '0;
                mis_q[g]  <= 1'b0;
                tgt_q[g]  <= '0;
            end else if (flush) begin
                v_q[g] <= 1'b0;
                r_q[g] <= 1'b0;
            end else begin
                if (hit_pop) begin
                    v_q[g] <= 1'b0;
                end
                if (hit_wb) begin
                    r_q[g]    <= 1'b1;
                    val_q[g]  <= wb_value;
                    addr_q[g] <= wb_addr;
                    mis_q[g]  <= wb_mis;
                    tgt_q[g]  <= wb_target;
                end
                if (hit_alloc) begin
                    v_q[g]    <= 1'b1;
                    r_q[g]    <= 1'b0;
                    kind_q[g] <= alloc_kind;
                    dest_q[g] <= alloc_dest;
                    mis_q[g]  <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        hd_valid  = v_q[head_idx];
        hd_ready  = r_q[head_idx];
        hd_kind   = kind_q[head_idx];
        hd_dest   = dest_q[head_idx];
        hd_value  = val_q[head_idx];
        hd_addr   = addr_q[head_idx];
        hd_mis    = mis_q[head_idx];
        hd_target = tgt_q[head_idx];
    end

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic [ADDR_W-1:0] flush_target,
    output logic              run_ok,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);

    rob_state_e        state_q;
    logic [ADDR_W-1:0] target_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            target_q <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (flush_req) begin
                        state_q  <= ST_REDIRECT;
                        target_q <= flush_target;
                    end
                end
                ST_REDIRECT: begin
                    state_q <= ST_RUN;
                end
            endcase
        end
    end

    always_comb begin
        run_ok         = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = target_q;
        unique case (state_q)
            ST_RUN:      run_ok = 1'b1;
            ST_REDIRECT: redirect_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_mispredict,
    input  logic [ADDR_W-1:0] wb_target,
    output logic              commit_valid,
    output logic [TAG_W-1:0]  commit_tag,
    output logic [1:0]        commit_kind,
    output logic              reg_we,
    output logic [REG_W-1:0]  reg_dest,
    output logic [DATA_W-1:0] reg_value,
    output logic              store_we,
    output logic [ADDR_W-1:0] store_addr,
    output logic [DATA_W-1:0] store_data,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);

    localparam int CNT_W = TAG_W + 1;

    logic [TAG_W-1:0]  head;
    logic [TAG_W-1:0]  tail;
    logic [CNT_W-1:0]  occ_count;
    logic              full;
    logic              empty;
    logic              run_ok;
    logic              alloc_fire;
    logic              commit_fire;
    logic              flush_now;

    logic              hd_valid;
    logic              hd_ready;
    rob_kind_e         hd_kind;
    logic [REG_W-1:0]  hd_dest;
    logic [DATA_W-1:0] hd_value;
    logic [ADDR_W-1:0] hd_addr;
    logic              hd_mis;
    logic [ADDR_W-1:0] hd_target;

    assign full        = (occ_count == CNT_W'(DEPTH));
    assign empty       = (occ_count == '0);
    assign commit_fire = run_ok && !empty && hd_valid && hd_ready;
    assign flush_now   = commit_fire && (hd_kind == K_BRANCH) && hd_mis;
    assign alloc_ready = run_ok && !full && !flush_now;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (alloc_fire),
        .pop   (commit_fire),
        .flush (flush_now),
        .head  (head),
        .tail  (tail),
        .count (occ_count)
    );

    rob_store #(
        .DEPTH  (DEPTH),
        .REG_W  (REG_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_now),
        .alloc_we   (alloc_fire),
        .alloc_idx  (tail),
        .alloc_kind (rob_kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .wb_we      (wb_valid),
        .wb_idx     (wb_tag),
        .wb_value   (wb_value),
        .wb_addr    (wb_addr),
        .wb_mis     (wb_mispredict),
        .wb_target  (wb_target),
        .pop        (commit_fire),
        .head_idx   (head),
        .hd_valid   (hd_valid),
        .hd_ready   (hd_ready),
        .hd_kind    (hd_kind),
        .hd_dest    (hd_dest),
        .hd_value   (hd_value),
        .hd_addr    (hd_addr),
        .hd_mis     (hd_mis),
        .hd_target  (hd_target)
    );

    rob_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_req      (flush_now),
        .flush_target   (hd_target),
        .run_ok         (run_ok),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_comb begin
        commit_valid = commit_fire;
        commit_tag   = head;
        commit_kind  = hd_kind;
        reg_dest     = hd_dest;
        reg_value    = hd_value;
        store_addr   = hd_addr;
        store_data   = hd_value;
        reg_we       = 1'b0;
        store_we     = 1'b0;
        unique case (hd_kind)
            K_ALU, K_LOAD: reg_we   = commit_fire;
            K_STORE:       store_we = commit_fire;
            K_BRANCH:      ;
        endcase
    end

endmodule

// File: rtl/rob_core_checker.sv
module rob_core_checker #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             commit_valid,
    input logic [TAG_W-1:0] commit_tag,
    input logic [1:0]       commit_kind,
    input logic             reg_we,
    input logic             store_we,
    input logic             redirect_valid,
    input logic [TAG_W:0]   occ_count
);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_count <= (TAG_W+1)'(DEPTH));

    p_no_alloc_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_count == (TAG_W+1)'(DEPTH)) |-> !alloc_ready);

    p_commit_in_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (!commit_valid || commit_tag == $past(commit_tag) + TAG_W'(1)));

    p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && store_we));

    p_write_needs_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || store_we) |-> commit_valid);

    p_branch_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_kind == 2'd3) |-> (!reg_we && !store_we));

    p_redirect_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    p_redirect_after_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ($past(commit_valid) && $past(commit_kind) == 2'd3));

    p_quiet_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!commit_valid && !alloc_ready));

endmodule

bind rob_core rob_core_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_ready    (alloc_ready),
    .commit_valid   (commit_valid),
    .commit_tag     (commit_tag),
    .commit_kind    (commit_kind),
    .reg_we         (reg_we),
    .store_we       (store_we),
    .redirect_valid (redirect_valid),
    .occ_count      (occ_count)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;

    localparam int DEPTH  = 8;
    localparam int TAG_W  = 3;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int NVEC   = 6;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  dest;
        logic [31:0] value;
        logic [31:0] addr;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 5'd1, 32'h0000_0011, 32'h0},
        '{2'd1, 5'd2, 32'h0000_0022, 32'h0},
        '{2'd2, 5'd0, 32'h0000_0033, 32'h0000_0400},
        '{2'd0, 5'd4, 32'h0000_0044, 32'h0},
        '{2'd2, 5'd0, 32'h0000_0055, 32'h0000_0408},
        '{2'd1, 5'd6, 32'h0000_0066, 32'h0}
    };

    logic              clk;
    logic              rst_n;
    logic              alloc_valid;
    logic [1:0]        alloc_kind;
    logic [REG_W-1:0]  alloc_dest;
    logic              alloc_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic              wb_valid;
    logic [TAG_W-1:0]  wb_tag;
    logic [DATA_W-1:0] wb_value;
    logic [ADDR_W-1:0] wb_addr;
    logic              wb_mispredict;
    logic [ADDR_W-1:0] wb_target;
    logic              commit_valid;
    logic [TAG_W-1:0]  commit_tag;
    logic [1:0]        commit_kind;
    logic              reg_we;
    logic [REG_W-1:0]  reg_dest;
    logic [DATA_W-1:0] reg_value;
    logic              store_we;
    logic [ADDR_W-1:0] store_addr;
    logic [DATA_W-1:0] store_data;
    logic              redirect_valid;
    logic [ADDR_W-1:0] redirect_pc;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    rob_core #(
        .DEPTH  (DEPTH),
        .REG_W  (REG_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rob_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid    (alloc_valid),
        .alloc_kind     (alloc_kind),
        .alloc_dest     (alloc_dest),
        .alloc_ready    (alloc_ready),
        .alloc_tag      (alloc_tag),
        .wb_valid       (wb_valid),
        .wb_tag         (wb_tag),
        .wb_value       (wb_value),
        .wb_addr        (wb_addr),
        .wb_mispredict  (wb_mispredict),
        .wb_target      (wb_target),
        .commit_valid   (commit_valid),
        .commit_tag     (commit_tag),
        .commit_kind    (commit_kind),
        .reg_we         (reg_we),
        .reg_dest       (reg_dest),
        .reg_value      (reg_value),
        .store_we       (store_we),
        .store_addr     (store_addr),
        .store_data     (store_data),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid   = 1'b0;
        alloc_kind    = 2'd0;
        alloc_dest    = '0;
        wb_valid      = 1'b0;
        wb_tag        = '0;
        wb_value      = '0;
        wb_addr       = '0;
        wb_mispredict = 1'b0;
        wb_target     = '0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic put_alloc(input logic [1:0] k, input logic [4:0] d);
        alloc_valid = 1'b1;
        alloc_kind  = k;
        alloc_dest  = d;
    endtask

    task automatic put_wb(input logic [2:0] t, input logic [31:0] v, input logic [31:0] a,
                          input logic m, input logic [31:0] tg);
        wb_valid      = 1'b1;
        wb_tag        = t;
        wb_value      = v;
        wb_addr       = a;
        wb_mispredict = m;
        wb_target     = tg;
    endtask

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            print_summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        sample();
        check("R1 alloc_ready", 32'(alloc_ready), 1);
        check("R1 alloc_tag", 32'(alloc_tag), 0);
        check("R1 commit_valid", 32'(commit_valid), 0);
        check("R1 redirect_valid", 32'(redirect_valid), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R2: table walk, allocate in order
        for (int i = 0; i < NVEC; i++) begin
            put_alloc(VEC[i].kind, VEC[i].dest);
            sample();
            check("R2 alloc_ready", 32'(alloc_ready), 1);
            check("R2 alloc_tag", 32'(alloc_tag), 32'(i));
            next_cycle();
        end
        // R4: results return youngest first; nothing may commit yet
        for (int i = NVEC - 1; i >= 0; i--) begin
            put_wb(3'(i), VEC[i].value, VEC[i].addr, 1'b0, 32'h0);
            sample();
            check("R4 no early commit", 32'(commit_valid), 0);
            next_cycle();
        end
        // R5 R6: commits in program order, one per cycle
        for (int i = 0; i < NVEC; i++) begin
            sample();
            check("R4 commit_valid", 32'(commit_valid), 1);
            check("R4 commit_tag", 32'(commit_tag), 32'(i));
            check("R5 reg_we", 32'(reg_we), 32'(VEC[i].kind < 2'd2));
            check("R6 store_we", 32'(store_we), 32'(VEC[i].kind == 2'd2));
            if (VEC[i].kind < 2'd2) begin
                check("R5 reg_dest", 32'(reg_dest), 32'(VEC[i].dest));
                check("R5 reg_value", reg_value, VEC[i].value);
            end else begin
                check("R6 store_addr", store_addr, VEC[i].addr);
                check("R6 store_data", store_data, VEC[i].value);
            end
            next_cycle();
        end
        sample();
        check("R4 drained", 32'(commit_valid), 0);
        next_cycle();

        // R7: correctly predicted branch (tag 6) then ALU (tag 7)
        put_alloc(2'd3, 5'd0);
        next_cycle();
        put_alloc(2'd0, 5'd9);
        next_cycle();
        put_wb(3'd7, 32'h0000_0777, 32'h0, 1'b0, 32'h0);
        next_cycle();
        put_wb(3'd6, 32'h0, 32'h0, 1'b0, 32'h0000_9999);
        next_cycle();
        sample();
        check("R7 branch commits", 32'(commit_valid), 1);
        check("R7 branch tag", 32'(commit_tag), 6);
        check("R7 branch no write", 32'({reg_we, store_we}), 0);
        next_cycle();
        sample();
        check("R7 no redirect", 32'(redirect_valid), 0);
        check("R7 follower commits", 32'(commit_valid), 1);
        check("R7 follower tag", 32'(commit_tag), 7);
        check("R7 follower value", reg_value, 32'h0000_0777);
        next_cycle();

        // R8: ALU tag0, BRANCH tag1, ALU tag2, STORE tag3
        put_alloc(2'd0, 5'd1);  next_cycle();
        put_alloc(2'd3, 5'd0);  next_cycle();
        put_alloc(2'd0, 5'd2);  next_cycle();
        put_alloc(2'd2, 5'd0);  next_cycle();
        put_wb(3'd2, 32'h0000_00C2, 32'h0, 1'b0, 32'h0);  next_cycle();
        put_wb(3'd3, 32'h0000_00C3, 32'h0000_0500, 1'b0, 32'h0);  next_cycle();
        put_wb(3'd0, 32'h0000_00A0, 32'h0, 1'b0, 32'h0);  next_cycle();
        put_wb(3'd1, 32'h0, 32'h0, 1'b1, 32'h0000_1234);
        sample();
        check("R8 older commits first", 32'(commit_tag), 0);
        check("R8 older reg_value", reg_value, 32'h0000_00A0);
        next_cycle();
        put_alloc(2'd0, 5'd3);
        sample();
        check("R8 branch commits", 32'(commit_valid), 1);
        check("R8 branch tag", 32'(commit_tag), 1);
        check("R8 branch no write", 32'({reg_we, store_we}), 0);
        check("R8 alloc refused in flush", 32'(alloc_ready), 0);
        check("R8 redirect not yet", 32'(redirect_valid), 0);
        next_cycle();
        sample();
        check("R8 redirect_valid", 32'(redirect_valid), 1);
        check("R8 redirect_pc", redirect_pc, 32'h0000_1234);
        check("R8 no commit in redirect", 32'(commit_valid), 0);
        check("R8 alloc refused in redirect", 32'(alloc_ready), 0);
        next_cycle();
        sample();
        check("R8 redirect one cycle", 32'(redirect_valid), 0);
        check("R8 younger discarded", 32'(commit_valid), 0);
        check("R10 alloc_ready", 32'(alloc_ready), 1);
        check("R10 alloc_tag after flush", 32'(alloc_tag), 2);
        next_cycle();

        // R9: stray writeback to free slot 2, then allocate slot 2
        put_wb(3'd2, 32'h0000_0055, 32'h0, 1'b0, 32'h0);
        sample();
        check("R8 still discarded", 32'(commit_valid), 0);
        next_cycle();
        put_alloc(2'd0, 5'd12);
        sample();
        check("R10 new tag", 32'(alloc_tag), 2);
        next_cycle();
        for (int k = 0; k < 2; k++) begin
            sample();
            check("R9 waits for own result", 32'(commit_valid), 0);
            next_cycle();
        end
        put_wb(3'd2, 32'h0000_0077, 32'h0, 1'b0, 32'h0);
        next_cycle();
        sample();
        check("R9 commit_valid", 32'(commit_valid), 1);
        check("R9 commit_tag", 32'(commit_tag), 2);
        check("R9 reg_value", reg_value, 32'h0000_0077);
        check("R9 reg_dest", 32'(reg_dest), 12);
        next_cycle();

        // R3: fill all 8 slots starting at tag 3, across the wrap
        for (int i = 0; i < DEPTH; i++) begin
            put_alloc(2'd0, 5'(i + 16));
            sample();
            check("R3 accept while room", 32'(alloc_ready), 1);
            check("R2 wrap tag", 32'(alloc_tag), 32'((3 + i) % DEPTH));
            next_cycle();
        end
        put_alloc(2'd0, 5'd31);
        sample();
        check("R3 full refuses", 32'(alloc_ready), 0);
        next_cycle();
        for (int i = 0; i < DEPTH; i++) begin
            put_wb(3'((3 + i) % DEPTH), 32'(32'h100 + i), 32'h0, 1'b0, 32'h0);
            sample();
            if (i == 0) begin
                check("R3 none before result", 32'(commit_valid), 0);
            end else begin
                check("R3 commit_tag", 32'(commit_tag), 32'((3 + i - 1) % DEPTH));
                check("R3 reg_value", reg_value, 32'(32'h100 + i - 1));
            end
            next_cycle();
        end
        sample();
        check("R3 last commit_tag", 32'(commit_tag), 32'((3 + DEPTH - 1) % DEPTH));
        check("R3 last reg_dest", 32'(reg_dest), 32'(16 + DEPTH - 1));
        next_cycle();
        for (int k = 0; k < 3; k++) begin
            sample();
            check("R3 no ninth entry", 32'(commit_valid), 0);
            next_cycle();
        end
        sample();
        check("R3 tail unchanged by refused request", 32'(alloc_tag), 3);

        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule